// File: doc/BRIEF.md
# Dual Calendar Alarm Comparator with Power-Off Request

This block watches a running BCD calendar (seconds, minutes, hours, day, month, year) supplied by a separate counter. It compares that calendar against two alarm registers of its own. An alarm fires only when all six of its fields equal the present time. No field can be left out of the comparison. Each firing sets a sticky status flag, which stays set until software writes a one to it. Every one-second update also sets a third sticky flag for the periodic timer. The interrupt output is raised by any flag whose enable bit is set. A separate wake output follows the first alarm's flag when wake is enabled.

The second alarm can also switch off an external supply. When the power-control bit is set, a second-alarm event drives the active-high power-enable output low. That output stays low until the block is reset. Software programs the block through a simple write port: one write strobe, a byte address and a 32-bit data word. The status flags are visible on a status output.

The comparison is run by a three-state sequencer. SEQ_IDLE waits for the one-second strobe and moves to SEQ_SETTLE. SEQ_SETTLE gives the time fields one cycle to settle and always moves to SEQ_CMP. SEQ_CMP compares both alarms, records the events and always returns to SEQ_IDLE. A strobe that arrives while the sequencer is outside SEQ_IDLE is ignored. A second state machine tracks the supply. PWR_ON moves to PWR_OFF on a second-alarm event while power control is set. PWR_OFF has no exit except reset.

Top module: `dual_alarm_ctrl`

## Requirements
- R1: Alarm 1 fields are written at byte addresses 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, and alarm 2 fields at 0x80, 0x84, 0x88, 0x8C, 0x90, 0x94. In both sets the order is seconds, minutes, hours, day, month, year, and each register takes data bits 7:0.
- R2: An alarm event happens only when all six alarm fields equal the six time inputs. A difference in any single field gives no event.
- R3: Comparison happens only in SEQ_CMP. With the strobe sampled high at clock edge E1 in SEQ_IDLE, the status flags update at edge E1+2 and are still unchanged after edge E1+1. Without a strobe there is no event, even when the time matches.
- R4: At each comparison, status bit 2 (timer) is set. Status bit 6 is set by an alarm 1 event and status bit 7 by an alarm 2 event. The flags are independent of each other, and the output `status` shows them.
- R5: Writing to address 0x44 clears each status bit whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R6: `irq` is high while any of these pairs is set: status bit 6 with enable 0x48 bit 3, status bit 7 with 0x48 bit 4, or status bit 2 with 0x48 bit 2. Otherwise `irq` is low.
- R7: `wake` is high exactly while status bit 6 is set and wake-enable register 0x7C bit 1 is set.
- R8: `pwr_en` is 1 during and after reset. It goes to 0 with an alarm 2 event only when power control 0x98 bit 16 is set. It then stays 0 until reset, even after bit 7 is cleared. Without bit 16, alarm 2 events leave it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| tick | input | 1 | One-second update strobe, one cycle wide |
| now_sec | input | 8 | Present seconds, BCD |
| now_min | input | 8 | Present minutes, BCD |
| now_hour | input | 8 | Present hours, BCD |
| now_day | input | 8 | Present day of month, BCD |
| now_mon | input | 8 | Present month, BCD |
| now_year | input | 8 | Present year, BCD |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request from alarm 1 |
| pwr_en | output | 1 | External supply enable, 0 requests power-off |
| status | output | 8 | Sticky flags: bit 7 alarm 2, bit 6 alarm 1, bit 2 timer |

## Verification
A stuck or wrong sequencer state shows up on `status`. The flags either never rise after a strobe, or they rise one edge early or late. The bench measures this at the exact edge. A wrong stored alarm field hides until a tick whose time equals the intended alarm. That is why each field is tested separately by a one-off mismatch, and each such test is visible after three edges. A power state machine that leaves PWR_OFF is caught on `pwr_en` when alarm 2's flag is cleared.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;

    localparam int FIELDS     = 6;
    localparam int BCD_W      = 8;
    localparam int NUM_ALARMS = 2;

    localparam logic [7:0] A1_BASE   = 8'h20;
    localparam logic [7:0] A2_BASE   = 8'h80;
    localparam logic [7:0] STAT_OFS  = 8'h44;
    localparam logic [7:0] IEN_OFS   = 8'h48;
    localparam logic [7:0] WKEN_OFS  = 8'h7C;
    localparam logic [7:0] PCTL_OFS  = 8'h98;

    localparam int ST_TMR = 2;
    localparam int ST_A1  = 6;
    localparam int ST_A2  = 7;
    localparam int IE_TMR = 2;
    localparam int IE_A1  = 3;
    localparam int IE_A2  = 4;
    localparam int WK_A1  = 1;
    localparam int PC_EN  = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_CMP    = 2'd2
    } seq_state_e;

    typedef enum logic {
        PWR_ON  = 1'b0,
        PWR_OFF = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/alarm_bank.sv
module alarm_bank
    import dual_alarm_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                FLD_N   = FIELDS,
    parameter int                FLD_W   = BCD_W,
    parameter int                STRIDE  = 4,
    parameter logic [ADDR_W-1:0] BASE    = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [FLD_W-1:0]         wr_byte,
    input  logic [FLD_N*FLD_W-1:0]   now_vec,
    output logic                     match
);

    logic [FLD_N-1:0] fld_eq;

    for (genvar f = 0; f < FLD_N; f++) begin : g_fld
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(int'(BASE) + f * STRIDE);
        logic [FLD_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_addr == OFS)) begin
                val_q <= wr_byte;
            end
        end

        assign fld_eq[f] = (val_q == now_vec[f*FLD_W +: FLD_W]);
    end

    assign match = &fld_eq;

endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
    import dual_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic cmp_now
);

    seq_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:   if (tick) st_d = SEQ_SETTLE;
            SEQ_SETTLE: st_d = SEQ_CMP;
            SEQ_CMP:    st_d = SEQ_IDLE;
            default:    st_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        cmp_now = (st_q == SEQ_CMP);
    end

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
    import dual_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic a2_evt,
    output logic pwr_en
);

    pwr_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PWR_ON;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PWR_ON:  if (armed && a2_evt) st_d = PWR_OFF;
            PWR_OFF: st_d = PWR_OFF;
            default: st_d = PWR_ON;
        endcase
    end

    always_comb begin
        pwr_en = (st_q == PWR_ON);
    end

endmodule

// File: rtl/dual_alarm_ctrl.sv
module dual_alarm_ctrl
    import dual_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        now_day,
    input  logic [7:0]        now_mon,
    input  logic [7:0]        now_year,
    output logic              irq,
    output logic              wake,
    output logic              pwr_en,
    output logic [STAT_W-1:0] status
);

    localparam logic [STAT_W-1:0] STAT_MASK =
        STAT_W'((1 << ST_A2) | (1 << ST_A1) | (1 << ST_TMR));
    localparam logic [ADDR_W-1:0] BANK_BASE [NUM_ALARMS] = '{
        ADDR_W'(A1_BASE), ADDR_W'(A2_BASE)
    };

    logic [FIELDS*BCD_W-1:0] now_vec;
    logic [NUM_ALARMS-1:0]   hit;
    logic                    cmp_now;
    logic                    a1_evt;
    logic                    a2_evt;
    logic [STAT_W-1:0]       stat_q;
    logic [STAT_W-1:0]       set_v;
    logic [STAT_W-1:0]       clr_v;
    logic [IE_A2:IE_TMR]     ien_q;
    logic                    wken_q;
    logic                    pctl_q;
    logic                    unused_bits;

    assign now_vec = {now_year, now_mon, now_day, now_hour, now_min, now_sec};

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_bank
        alarm_bank #(
            .ADDR_W (ADDR_W),
            .FLD_N  (FIELDS),
            .FLD_W  (BCD_W),
            .STRIDE (4),
            .BASE   (BANK_BASE[a])
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_byte (wr_data[BCD_W-1:0]),
            .now_vec (now_vec),
            .match   (hit[a])
        );
    end

    alarm_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmp_now (cmp_now)
    );

    assign a1_evt = cmp_now && hit[0];
    assign a2_evt = cmp_now && hit[1];

    always_comb begin
        set_v         = '0;
        set_v[ST_TMR] = cmp_now;
        set_v[ST_A1]  = a1_evt;
        set_v[ST_A2]  = a2_evt;
        clr_v = (wr_en && (wr_addr == ADDR_W'(STAT_OFS))) ? wr_data[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_v) | set_v) & STAT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wken_q <= 1'b0;
            pctl_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(IEN_OFS))  ien_q  <= wr_data[IE_A2:IE_TMR];
            if (wr_addr == ADDR_W'(WKEN_OFS)) wken_q <= wr_data[WK_A1];
            if (wr_addr == ADDR_W'(PCTL_OFS)) pctl_q <= wr_data[PC_EN];
        end
    end

    pwr_ctrl pwr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (pctl_q),
        .a2_evt (a2_evt),
        .pwr_en (pwr_en)
    );

    always_comb begin
        irq = (stat_q[ST_A1]  && ien_q[IE_A1])
           || (stat_q[ST_A2]  && ien_q[IE_A2])
           || (stat_q[ST_TMR] && ien_q[IE_TMR]);
        wake   = stat_q[ST_A1] && wken_q;
        status = stat_q;
    end

    assign unused_bits = ^{wr_data[DATA_W-1:PC_EN+1], wr_data[PC_EN-1:STAT_W]};

endmodule

// File: rtl/dual_alarm_chk.sv
module dual_alarm_chk
    import dual_alarm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [7:0] status,
    input logic       wake,
    input logic       pwr_en,
    input logic       cmp_now
);

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[ST_A1]) || $rose(status[ST_A2]) || $rose(status[ST_TMR])) |-> $past(cmp_now));

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[ST_A1]) |-> $past(wr_en && (wr_addr == STAT_OFS) && wr_data[ST_A1]));

    // R3
    single_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_now |=> !cmp_now);

    // R7
    wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> status[ST_A1]);

    // R8
    pwr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pwr_en));

endmodule

bind dual_alarm_ctrl dual_alarm_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .status  (status),
    .wake    (wake),
    .pwr_en  (pwr_en),
    .cmp_now (cmp_now)
);

// File: tb/dual_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_alarm_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [7:0]  tv [6];
    logic        irq, wake, pwr_en;
    logic [7:0]  status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_alarm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick(tick), .now_sec(tv[0]), .now_min(tv[1]), .now_hour(tv[2]),
        .now_day(tv[3]), .now_mon(tv[4]), .now_year(tv[5]),
        .irq(irq), .wake(wake), .pwr_en(pwr_en), .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // k in 0..5 perturbs that field by one bit; k == 6 programs an exact match
    task automatic prog_alarm(input logic [7:0] base, input int k);
        for (int f = 0; f < 6; f++) begin
            wr(8'(base + 8'(4 * f)), {24'h0, tv[f] ^ ((f == k) ? 8'h01 : 8'h00)});
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tv[0] = 8'h59; tv[1] = 8'h58; tv[2] = 8'h23;
        tv[3] = 8'h31; tv[4] = 8'h12; tv[5] = 8'h99;
        repeat (3) @(negedge clk);
        check("R8 reset pwr_en", pwr_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset status", status, 0);
        check("R6 reset irq", irq, 0);
        check("R7 reset wake", wake, 0);
        check("R8 pwr_en after reset", pwr_en, 1);

        // R2 sweep: each single-field mismatch on alarm 1 and alarm 2 gives no event
        for (int a = 0; a < 2; a++) begin
            for (int k = 0; k < 6; k++) begin
                prog_alarm(a == 0 ? 8'h20 : 8'h80, k);
                do_tick();
                check("R2 mismatch no event", status[7:6], 2'b00);
                check("R4 timer flag per tick", status[2], 1);
                wr(8'h44, 32'h4);
                check("R5 timer flag cleared", status[2], 0);
            end
        end

        // R3: exact alarm 1 match but no tick -> no event
        prog_alarm(8'h20, 6);
        repeat (6) @(negedge clk);
        check("R3 no tick no event", status, 0);

        // R3 edge timing: unchanged after E1+1, set after E1+2
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        check("R3 before compare", status, 8'h00);
        @(negedge clk);
        check("R3 R1 alarm1 at 0x20..0x34 fires", status, 8'h44);

        // R6, R7 enable gating
        check("R6 irq masked", irq, 0);
        check("R7 wake masked", wake, 0);
        wr(8'h48, 32'h8);
        check("R6 irq alarm1", irq, 1);
        wr(8'h7C, 32'h2);
        check("R7 wake on", wake, 1);
        wr(8'h44, 32'h0);
        check("R5 zero write keeps flags", status, 8'h44);
        wr(8'h44, 32'h40);
        check("R5 clear alarm1 only", status, 8'h04);
        check("R6 irq off after clear", irq, 0);
        check("R7 wake off after clear", wake, 0);
        wr(8'h48, 32'h4);
        check("R6 irq timer", irq, 1);
        wr(8'h44, 32'h4);
        check("R6 irq timer cleared", irq, 0);

        // R8: alarm 2 match without power control
        prog_alarm(8'h20, 0);
        prog_alarm(8'h80, 6);
        do_tick();
        check("R4 R1 alarm2 only at 0x80..0x94", status, 8'h84);
        check("R8 no power control", pwr_en, 1);
        wr(8'h48, 32'h10);
        check("R6 irq alarm2", irq, 1);
        wr(8'h44, 32'hC4);
        check("R5 clear all", status, 0);

        // R8: power control armed, mismatch then match
        wr(8'h98, 32'h0001_0000);
        prog_alarm(8'h80, 5);
        do_tick();
        check("R8 mismatch keeps power", pwr_en, 1);
        prog_alarm(8'h80, 6);
        do_tick();
        check("R8 alarm2 drops power", pwr_en, 0);
        check("R4 alarm2 flag", status[7], 1);
        wr(8'h44, 32'h84);
        check("R8 power stays off", pwr_en, 0);
        wr(8'h98, 32'h0);
        check("R8 power stays off unarmed", pwr_en, 0);

        // both alarms at once
        prog_alarm(8'h20, 6);
        do_tick();
        check("R4 both flags", status, 8'hC4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule